// File: doc/BRIEF.md
# Two-Stage Runaway Watchdog

This block guards a processor against a program that has lost its way. A down counter runs on a per-instruction tick. Each time it passes through zero it advances a pair of status flags. The first pass raises the first flag. A second pass while that flag is still up raises the second flag, and raising the second flag requests a system reset. Software keeps the system alive by issuing a service command. That command clears only the first flag and leaves the counter running, so a program that services it at least once in every counter period never gets reset.

After reset the watchdog sits idle and holds its counter at all ones. A start command arms it, and from then on it cannot be disarmed. The reset request lasts one cycle. In the cycle after it, the block clears both flags and reloads the counter, so the sequence starts over.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset, flag1_o, flag2_o and reset_req_o are all 0.
- R2: Until start_i has been seen high at a clock edge, no flag rises and no reset request occurs, whatever tick_i and service_i do.
- R3: With tick_i held high, flag1_o rises at the edge 2^CNT_W cycles after the edge that captured start_i. The counter starts from all ones, counts down once per tick and wraps from zero to all ones.
- R4: The counter changes only on edges where tick_i is 1, so cycles with tick_i at 0 delay the underflow by exactly that many cycles.
- R5: service_i clears flag1_o at the next edge and does not reload the counter. The next underflow then raises flag1_o again without any reset request.
- R6: An underflow while flag1_o is 1 and service_i is 0 sets flag2_o and reset_req_o together for exactly one cycle.
- R7: In the cycle after a reset request, both flags clear and the counter reloads to all ones. The next flag1_o rise comes 2^CNT_W cycles after reset_req_o falls.
- R8: If service_i coincides with an underflow, service wins: flag1_o ends at 0 and no reset request is raised.
- R9: A further start_i pulse while the watchdog is armed has no effect on counting or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-clock enable; counter steps when high |
| start_i | input | 1 | Arms the watchdog (sticky) |
| service_i | input | 1 | Service command; clears the first flag |
| reset_req_o | output | 1 | One-cycle system reset request |
| flag1_o | output | 1 | First timeout flag |
| flag2_o | output | 1 | Second timeout flag |

## Verification
The properties assume that the reset request is consumed outside the block and does not feed back into rst_n in the same cycle. They also assume that tick_i, start_i and service_i are synchronous single-bit levels. The bench changes every input only at the falling edge, pulses start_i and service_i for one cycle each, and gates tick_i only in whole cycles. A reduced counter width keeps each wrap period short, so the two-underflow sequences complete within the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef struct packed {
      logic stage2;
      logic stage1;
   } wdt_flags_t;

   localparam int unsigned WDT_MIN_W = 2;
   localparam int unsigned WDT_MAX_W = 32;
endpackage

// File: rtl/wdt_arm.sv
module wdt_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic armed_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_o <= 1'b0;
      else if (start_i) armed_o <= 1'b1;
   end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         tick_i,
   input  logic         reload_i,
   output logic [W-1:0] cnt_o,
   output logic         underflow_o
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   logic step;
   assign step        = run_i && tick_i && !reload_i;
   assign underflow_o = step && (cnt_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_o <= ALL_ONES;
      else if (reload_i)    cnt_o <= ALL_ONES;
      else if (underflow_o) cnt_o <= ALL_ONES;
      else if (step)        cnt_o <= cnt_o - ONE;
   end
endmodule

// File: rtl/wdt_flag_pair.sv
module wdt_flag_pair
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       underflow_i,
   input  logic       service_i,
   output wdt_flags_t flags_o
);
   wdt_flags_t nxt;

   always_comb begin
      nxt = flags_o;
      if (flags_o.stage2) begin
         nxt = '0;
      end else if (service_i) begin
         nxt.stage1 = 1'b0;
      end else if (underflow_i) begin
         if (flags_o.stage1) nxt.stage2 = 1'b1;
         else                nxt.stage1 = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o <= '0;
      else        flags_o <= nxt;
   end
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic start_i,
   input  logic service_i,
   output logic reset_req_o,
   output logic flag1_o,
   output logic flag2_o
);
   generate
      if (CNT_W < WDT_MIN_W || CNT_W > WDT_MAX_W) begin : g_bad_width
         $error("dual_stage_watchdog: CNT_W out of range");
      end
   endgenerate

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             uf;
   wdt_flags_t       flags;

   wdt_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .armed_o (en_q)
   );

   wdt_down_counter #(.W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (en_q),
      .tick_i      (tick_i),
      .reload_i    (flags.stage2),
      .cnt_o       (cnt_q),
      .underflow_o (uf)
   );

   wdt_flag_pair u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .underflow_i (uf),
      .service_i   (service_i),
      .flags_o     (flags)
   );

   assign flag1_o     = flags.stage1;
   assign flag2_o     = flags.stage2;
   assign reset_req_o = flags.stage2;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int unsigned CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             service_i,
   input logic             en,
   input logic [CNT_W-1:0] cnt,
   input logic             flag1,
   input logic             flag2,
   input logic             req
);
   AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!flag1 && !req)); // R2
   AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !req) |=> $stable(cnt)); // R4
   AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      service_i |=> !flag1); // R5
   AST_REQ_NEEDS_FLAG1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(flag1)); // R6
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req); // R6
   AST_REQ_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (!flag1 && !flag2 && (cnt == {CNT_W{1'b1}}))); // R7
   AST_SERVICE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (service_i && !req) |=> !req); // R8
endmodule

bind dual_stage_watchdog wdt_checker #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .service_i (service_i),
   .en        (en_q),
   .cnt       (cnt_q),
   .flag1     (flag1_o),
   .flag2     (flag2_o),
   .req       (reset_req_o)
);

// File: tb/dual_stage_watchdog_tb_top.sv
module dual_stage_watchdog_tb_top;
   localparam int unsigned W   = 4;
   localparam int unsigned PER = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic start = 1'b0;
   logic service = 1'b0;
   logic req, f1, f2;
   int   n_chk = 0;
   int   n_bad = 0;
   int   req_seen = 0;
   int   cyc = 0;

   always #2 clk = ~clk;

   dual_stage_watchdog #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
      .service_i(service), .reset_req_o(req), .flag1_o(f1), .flag2_o(f2)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && req) req_seen <= req_seen + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b1; start = 1'b0; service = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      req_seen = 0;
   endtask

   task automatic pulse_start();
      start = 1'b1; step(1); start = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 flag1", f1, 0);
      chk("R1 flag2", f2, 0);
      chk("R1 req", req, 0);
   endtask

   task automatic t_idle();
      do_reset();
      for (int i = 0; i < 3 * PER; i++) begin
         service = (i % 5 == 0);
         step(1);
      end
      service = 1'b0;
      chk("R2 flag1 idle", f1, 0);
      chk("R2 no req idle", req_seen, 0);
   endtask

   task automatic t_first_uf();
      do_reset();
      pulse_start();
      step(PER - 1);
      chk("R3 flag1 before underflow", f1, 0);
      step(1);
      chk("R3 flag1 at underflow", f1, 1);
      chk("R3 no req", req, 0);
   endtask

   task automatic t_tick_gate();
      do_reset();
      pulse_start();
      tick = 1'b0;
      step(10);
      tick = 1'b1;
      step(PER - 1);
      chk("R4 flag1 delayed", f1, 0);
      step(1);
      chk("R4 flag1 after delay", f1, 1);
   endtask

   task automatic t_service();
      do_reset();
      pulse_start();
      step(PER + 3);
      service = 1'b1; step(1); service = 1'b0;
      chk("R5 flag1 cleared", f1, 0);
      step(PER - 5);
      chk("R5 flag1 still clear", f1, 0);
      step(1);
      chk("R5 flag1 raised again", f1, 1);
      chk("R5 no req", req_seen, 0);
   endtask

   task automatic t_timeout();
      do_reset();
      pulse_start();
      step(PER);
      step(PER - 1);
      chk("R6 req before", req, 0);
      step(1);
      chk("R6 req high", req, 1);
      chk("R6 flag2 high", f2, 1);
      step(1);
      chk("R6 req one cycle", req, 0);
      chk("R7 flag1 cleared", f1, 0);
      chk("R7 flag2 cleared", f2, 0);
      step(PER - 1);
      chk("R7 flag1 before reload period", f1, 0);
      step(1);
      chk("R7 flag1 after reload period", f1, 1);
      chk("R6 req count", req_seen, 1);
   endtask

   task automatic t_coincide();
      do_reset();
      pulse_start();
      step(PER);
      step(PER - 1);
      service = 1'b1; step(1); service = 1'b0;
      chk("R8 flag1 low", f1, 0);
      chk("R8 no req", req, 0);
      step(PER);
      chk("R8 next underflow flag1", f1, 1);
      chk("R8 still no req", req_seen, 0);
      step(PER);
      chk("R8 later timeout req", req, 1);
   endtask

   task automatic t_restart();
      do_reset();
      pulse_start();
      step(5);
      pulse_start();
      step(PER - 7);
      chk("R9 flag1 before", f1, 0);
      step(1);
      chk("R9 flag1 on schedule", f1, 1);
   endtask

   initial begin
      t_reset_state();
      t_idle();
      t_first_uf();
      t_tick_gate();
      t_service();
      t_timeout();
      t_coincide();
      t_restart();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (cyc > 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule